// File: doc/BRIEF.md
# I2S Bus Master Clocked from a Resampled Master Clock

This block is an I2S bus master that runs entirely in a fast core-clock domain. An external master clock arrives asynchronously. The block passes it through a synchroniser and an edge detector. Every detected master-clock rising edge toggles the bit clock, so the bit clock runs at half the master-clock rate. Because each bit-clock edge is moved onto the core-clock grid, the high and low phases take one of two neighbouring whole numbers of core cycles. Their long-run average still equals the nominal rate. As an option, the bit clock can be retimed through one flop clocked directly by the master clock, which removes that quantisation.

A frame holds 64 bit slots: a left sample followed by a right sample, each 32 bits wide and sent MSB first. A small state machine tracks the channel and has three states. IDLE holds after reset until the first bit-clock falling edge, then moves to LEFT. LEFT moves to RIGHT on the falling edge that enters slot 32. RIGHT returns to LEFT on the falling edge that wraps to slot 0. The word clock is high only in RIGHT. It therefore changes one bit slot before the MSB of each channel.

DAC bits launch on bit-clock falling edges. ADC bits are captured on bit-clock rising edges. At each frame start the block takes a new left/right pair from its input ports and marks the cycle with a load pulse. Each complete ADC pair is presented with a one-cycle valid pulse.

Top module: `i2s_core_master`

## Requirements
- R1: While reset is asserted, bclk_o, lrclk_o, dac_o, tx_load_o and rx_valid_o are 0, and rx_left_o and rx_right_o are 0.
- R2: The master clock passes through a synchroniser of SYNC_STAGES flops and a rising-edge detector. Each detected rising edge toggles the bit clock exactly once, so the bit clock is the master clock divided by 2.
- R3: Bit-clock edges fall only on core-clock edges. When the master-clock period is not a whole number of core periods, each bit-clock phase lasts either the floor or the ceiling of that ratio in core cycles, both values occur, and the long-run average equals the ratio.
- R4: Falling edges of the bit clock are numbered 1, 2, 3, ... from reset, and slot c is the edge count modulo 64. The word clock is 0 (left) in slots 0 to 31 and 1 (right) in slots 32 to 63. It changes only on a bit-clock falling edge.
- R5: dac_o changes only on bit-clock falling edges. Slots 1 to 32 carry the left word, MSB first. Slots 33 to 63, then slot 0 of the next frame, carry the right word, MSB first.
- R6: tx_left_i and tx_right_i are sampled on the falling edge that enters slot 1. tx_load_o pulses for exactly that one core cycle, once per frame.
- R7: adc_i is sampled on each bit-clock rising edge. It uses the same slot alignment as the DAC stream: the rising edge in slot 1 carries the left MSB, and the rising edge in slot 0 carries the right LSB.
- R8: rx_valid_o pulses for one core cycle after the rising edge in slot 0 that completes a frame, with rx_left_o and rx_right_o holding that pair. No pulse occurs before the first complete frame.
- R9: With RETIME_BCLK set to 1, bclk_o changes only on master-clock rising edges, and each phase lasts exactly one master-clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_i | input | 1 | External master clock, asynchronous to clk |
| adc_i | input | 1 | Serial ADC data from the codec |
| tx_left_i | input | SAMPLE_W | Left DAC sample |
| tx_right_i | input | SAMPLE_W | Right DAC sample |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Word clock: 0 left, 1 right |
| dac_o | output | 1 | Serial DAC data |
| tx_load_o | output | 1 | One-cycle pulse when the DAC samples are taken |
| rx_left_o | output | SAMPLE_W | Last complete left ADC sample |
| rx_right_o | output | SAMPLE_W | Last complete right ADC sample |
| rx_valid_o | output | 1 | One-cycle pulse when a new ADC pair is ready |

## Verification
The bench builds the default 32-bit samples with two synchroniser stages, and drives a master clock of 3.4 core periods. That ratio makes bit-clock phases alternate between 3 and 4 core cycles, which brings the uneven-period pattern and its long-run average within reach of the checks. A second instance built with RETIME_BCLK set to 1 shares the same stimulus. It shows that the retimed bit clock lands exactly on master-clock edges with a uniform phase length. Sample patterns that exercise the top and bottom bits (all ones against all zeros, a set MSB and LSB against their complement) expose slot misalignment at either end of each channel.

// File: rtl/i2s_pkg.sv
package i2s_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } chan_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } bclk_evt_t;

endpackage

// File: rtl/i2s_mclk_sync.sv
module i2s_mclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mclk_async,
    output logic mclk_rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], mclk_async};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign mclk_rise = sync_q[STAGES-1] & ~last_q;

    // R2: a detected edge cannot repeat on the following cycle
    p_single_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_rise |=> !mclk_rise);

endmodule

// File: rtl/i2s_bclk_gen.sv
module i2s_bclk_gen
    import i2s_pkg::*;
#(
    parameter bit RETIME = 1'b0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mclk_async,
    input  logic      mclk_rise,
    output bclk_evt_t evt,
    output logic      bclk_pin
);
    logic bclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bclk_q <= 1'b0;
        else if (mclk_rise) bclk_q <= ~bclk_q;
    end

    always_comb begin
        evt.rise = mclk_rise & ~bclk_q;
        evt.fall = mclk_rise &  bclk_q;
    end

    generate
        if (RETIME) begin : g_retime
            logic rt_q;
            always_ff @(posedge mclk_async or negedge rst_n) begin
                if (!rst_n) rt_q <= 1'b0;
                else        rt_q <= bclk_q;
            end
            assign bclk_pin = rt_q;
        end else begin : g_direct
            assign bclk_pin = bclk_q;
        end
    endgenerate

    p_toggle_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_rise |=> (bclk_q != $past(bclk_q)));
    p_hold_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mclk_rise |=> $stable(bclk_q));

endmodule

// File: rtl/i2s_frame_fsm.sv
module i2s_frame_fsm
    import i2s_pkg::*;
#(
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  bclk_evt_t           evt,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    input  logic                adc_bit,
    output logic                lrclk,
    output logic                dac_bit,
    output logic                tx_load,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                rx_valid
);
    localparam int FRAME_W = 2 * SAMPLE_W;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_SLOT  = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] RIGHT_SLOT = CNT_W'(SAMPLE_W);
    localparam logic [CNT_W-1:0] MSB_SLOT   = CNT_W'(1);

    chan_state_e          state_q, state_d;
    logic [CNT_W-1:0]     slot_q, slot_nx;
    logic [FRAME_W-1:0]   tx_sh, rx_sh, rx_next;

    assign slot_nx = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
    assign rx_next = {rx_sh[FRAME_W-2:0], adc_bit};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (evt.fall) state_d = ST_LEFT;
            ST_LEFT:  if (evt.fall && slot_nx == RIGHT_SLOT) state_d = ST_RIGHT;
            ST_RIGHT: if (evt.fall && slot_nx == '0) state_d = ST_LEFT;
            default:  state_d = ST_IDLE;
        endcase
    end

    // slot counter, shifters and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q   <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            rx_left  <= '0;
            rx_right <= '0;
            rx_valid <= 1'b0;
            tx_load  <= 1'b0;
        end else begin
            tx_load  <= 1'b0;
            rx_valid <= 1'b0;
            if (evt.fall) begin
                slot_q <= slot_nx;
                if (slot_nx == MSB_SLOT) begin
                    tx_sh   <= {tx_left, tx_right};
                    tx_load <= 1'b1;
                end else begin
                    tx_sh <= tx_sh << 1;
                end
            end
            if (evt.rise) begin
                rx_sh <= rx_next;
                if (slot_q == '0 && state_q == ST_LEFT) begin
                    rx_left  <= rx_next[FRAME_W-1:SAMPLE_W];
                    rx_right <= rx_next[SAMPLE_W-1:0];
                    rx_valid <= 1'b1;
                end
            end
        end
    end

    assign lrclk   = (state_q == ST_RIGHT);
    assign dac_bit = tx_sh[FRAME_W-1];

    p_lr_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lrclk) |-> $past(evt.fall));
    p_dac_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_bit) |-> $past(evt.fall));
    p_load_left_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> (!lrclk && $past(evt.fall)));
    p_load_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !tx_load);
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    p_valid_after_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(evt.rise));

endmodule

// File: rtl/i2s_core_master.sv
module i2s_core_master
    import i2s_pkg::*;
#(
    parameter int SAMPLE_W    = 32,
    parameter int SYNC_STAGES = 2,
    parameter bit RETIME_BCLK = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mclk_i,
    input  logic                adc_i,
    input  logic [SAMPLE_W-1:0] tx_left_i,
    input  logic [SAMPLE_W-1:0] tx_right_i,
    output logic                bclk_o,
    output logic                lrclk_o,
    output logic                dac_o,
    output logic                tx_load_o,
    output logic [SAMPLE_W-1:0] rx_left_o,
    output logic [SAMPLE_W-1:0] rx_right_o,
    output logic                rx_valid_o
);
    logic      mclk_rise;
    bclk_evt_t bevt;

    i2s_mclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .mclk_async (mclk_i),
        .mclk_rise  (mclk_rise)
    );

    i2s_bclk_gen #(.RETIME(RETIME_BCLK)) u_bclk (
        .clk        (clk),
        .rst_n      (rst_n),
        .mclk_async (mclk_i),
        .mclk_rise  (mclk_rise),
        .evt        (bevt),
        .bclk_pin   (bclk_o)
    );

    i2s_frame_fsm #(.SAMPLE_W(SAMPLE_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (bevt),
        .tx_left  (tx_left_i),
        .tx_right (tx_right_i),
        .adc_bit  (adc_i),
        .lrclk    (lrclk_o),
        .dac_bit  (dac_o),
        .tx_load  (tx_load_o),
        .rx_left  (rx_left_o),
        .rx_right (rx_right_o),
        .rx_valid (rx_valid_o)
    );

    p_edges_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bevt.rise && bevt.fall));

endmodule

// File: tb/i2s_core_master_tb.sv
module i2s_core_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MCLK_HALF  = 17;
    localparam int SW         = 32;
    localparam int FW         = 2 * SW;
    localparam int FRAMES     = 6;

    logic clk = 1'b0, rst_n = 1'b0, mclk = 1'b0, adc = 1'b0;
    logic [SW-1:0] txl, txr;
    logic bclk, lrclk, dac, tx_load, rx_valid;
    logic [SW-1:0] rxl, rxr;
    logic rt_bclk, rt_lr, rt_dac, rt_load, rt_valid;
    logic [SW-1:0] rt_rxl, rt_rxr;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [FW-1:0] dac_q[$];
    logic [FW-1:0] adc_q[$];

    i2s_core_master #(.SAMPLE_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .mclk_i(mclk), .adc_i(adc),
        .tx_left_i(txl), .tx_right_i(txr), .bclk_o(bclk), .lrclk_o(lrclk),
        .dac_o(dac), .tx_load_o(tx_load), .rx_left_o(rxl), .rx_right_o(rxr),
        .rx_valid_o(rx_valid));

    i2s_core_master #(.SAMPLE_W(SW), .RETIME_BCLK(1'b1)) u_dut_rt (
        .clk(clk), .rst_n(rst_n), .mclk_i(mclk), .adc_i(adc),
        .tx_left_i(txl), .tx_right_i(txr), .bclk_o(rt_bclk), .lrclk_o(rt_lr),
        .dac_o(rt_dac), .tx_load_o(rt_load), .rx_left_o(rt_rxl), .rx_right_o(rt_rxr),
        .rx_valid_o(rt_valid));

    always #(CLK_PERIOD/2) clk = ~clk;
    initial begin
        #3;
        forever #MCLK_HALF mclk = ~mclk;
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] tx_pat(input int i);
        case (i)
            0: tx_pat = {32'hA5C3_0F81, 32'h1234_5678};
            1: tx_pat = {32'hFFFF_FFFF, 32'h0000_0000};
            2: tx_pat = {32'h8000_0001, 32'h7FFF_FFFE};
            default: tx_pat = {32'(i) * 32'h1F2E_3D4C, ~(32'(i) * 32'h0901_0203)};
        endcase
    endfunction

    function automatic logic [FW-1:0] codec_pat(input int f);
        case (f)
            1: codec_pat = {32'h0000_0000, 32'hFFFF_FFFF};
            2: codec_pat = {32'h8000_0001, 32'h4000_0002};
            default: codec_pat = {32'hC0DE_0000 ^ (32'(f) * 32'h0101_0101),
                                  32'h1357_9BDF + 32'(f)};
        endcase
    endfunction

    // driver: pushes each expected DAC frame when the block takes it
    initial begin
        {txl, txr} = tx_pat(0);
        for (int idx = 1; ; idx++) begin
            @(negedge clk iff tx_load);
            dac_q.push_back({txl, txr});
            #1 {txl, txr} = tx_pat(idx);
        end
    end

    // monitor / scoreboard
    int cyc = 0, last_tog = 0, first_tog = 0, ntog = 0, n3 = 0, n4 = 0;
    int fall_cnt = 0, nvalid = 0, mrise = 0;
    logic prev_bclk = 1'b0, prev_lr = 1'b0, prev_dac = 1'b0;
    logic [FW-1:0] cur_tx = '0, cur_adc = '0;

    always @(posedge mclk) if (rst_n) mrise++;

    always begin
        @(negedge clk);
        #2;
        if (rst_n && !done) begin
            cyc++;
            if (bclk != prev_bclk) begin
                if (ntog >= 3) begin
                    int iv;
                    iv = cyc - last_tog;
                    check("R3", "bclk phase length in {3,4}",
                          64'(iv == 3 || iv == 4), 64'd1);
                    if (iv == 3) n3++;
                    if (iv == 4) n4++;
                end
                if (ntog == 2) first_tog = cyc;
                last_tog = cyc;
                ntog++;
            end
            if (prev_bclk && !bclk) begin
                int p, c;
                fall_cnt++;
                c = fall_cnt % FW;
                p = (fall_cnt - 1) % FW;
                check("R4", "lrclk after fall", 64'(lrclk), 64'(c >= SW));
                if (p == 0) begin
                    check("R6", "tx_load at frame start", 64'(tx_load), 64'd1);
                    if (dac_q.size() == 0) begin
                        check("R6", "dac frame queued", 64'd0, 64'd1);
                    end else begin
                        cur_tx = dac_q.pop_front();
                    end
                    cur_adc = codec_pat(fall_cnt / FW);
                    adc_q.push_back(cur_adc);
                end else begin
                    check("R6", "no tx_load mid frame", 64'(tx_load), 64'd0);
                end
                check("R5", "dac bit", 64'(dac), 64'(cur_tx[FW-1-p]));
                adc = cur_adc[FW-1-p];
            end else begin
                check("R4", "lrclk stable off fall", 64'(lrclk), 64'(prev_lr));
                check("R5", "dac stable off fall", 64'(dac), 64'(prev_dac));
                check("R6", "tx_load only on fall", 64'(tx_load), 64'd0);
            end
            if (rx_valid) begin
                nvalid++;
                if (adc_q.size() == 0) begin
                    check("R8", "valid before complete frame", 64'd1, 64'd0);
                end else begin
                    logic [FW-1:0] e;
                    e = adc_q.pop_front();
                    check("R7", "rx_left", 64'(rxl), 64'(e[FW-1:SW]));
                    check("R7", "rx_right", 64'(rxr), 64'(e[SW-1:0]));
                end
            end
            prev_bclk = bclk;
            prev_lr   = lrclk;
            prev_dac  = dac;
        end
    end

    // retimed bit clock lands on master-clock rising edges only
    int nrt = 0;
    longint last_rt = 0;
    always @(rt_bclk) begin
        if (rst_n && !done) begin
            check("R9", "retimed edge on mclk rise",
                  64'(($time % (2 * MCLK_HALF)) == 20), 64'd1);
            if (nrt >= 3)
                check("R9", "retimed phase length", 64'($time - last_rt),
                      64'(2 * MCLK_HALF));
            last_rt = $time;
            nrt++;
        end
    end

    task automatic finish_run;
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        check("R1", "bclk in reset", 64'(bclk), 64'd0);
        check("R1", "lrclk in reset", 64'(lrclk), 64'd0);
        check("R1", "dac in reset", 64'(dac), 64'd0);
        check("R1", "tx_load in reset", 64'(tx_load), 64'd0);
        check("R1", "rx_valid in reset", 64'(rx_valid), 64'd0);
        check("R1", "rx data in reset", 64'({rxl, rxr}), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        wait (fall_cnt >= FW * FRAMES + 4);
        repeat (10) @(negedge clk);
        check("R3", "short phases seen", 64'(n3 > 0), 64'd1);
        check("R3", "long phases seen", 64'(n4 > 0), 64'd1);
        begin
            int span, num;
            span = (last_tog - first_tog) * 10;
            num  = (ntog - 3) * (2 * MCLK_HALF);
            check("R3", "average bclk phase", 64'(span >= num - 10 && span <= num + 10),
                  64'd1);
        end
        check("R2", "one bclk toggle per mclk rise",
              64'((mrise - ntog) >= -1 && (mrise - ntog) <= 2), 64'd1);
        check("R8", "valid count", 64'(nvalid), 64'(FRAMES));
        check("R9", "retimed edges observed", 64'(nrt > 100), 64'd1);
        finish_run();
    end

endmodule